// File: doc/BRIEF.md
# Discrete Latch Bank Switcher

This block is a cartridge bank-switching latch that sits on the bus of an 8-bit CPU. It turns CPU addresses into program ROM addresses and picture-side addresses into character ROM addresses. A CPU write anywhere in the upper half of the address space loads one 8-bit latch. The ROM also drives the data bus during that write, so the value that lands in the latch is the CPU data ANDed bit by bit with the ROM byte at the written address. The block models this bus conflict directly.

The `VARIANT` parameter picks one of two layouts:

- **Variant 0.** The 16 kB window at 0x8000 follows the latch. The window at 0xC000 always shows the last 16 kB bank. Character memory is a single fixed 8 kB.
- **Variant 1.** One latch holds two fields: a 32 kB program bank in bits 5:4, and an 8 kB character bank in bits 1:0.

Nametable mirroring is a static strap input. It selects whether picture address bit 10 or bit 11 picks the nametable page.

Top module: `discrete_bank_latch`

## Requirements
- R1: The latch loads on a rising clock edge only when `cpu_we` and `cpu_ce` are both high and `cpu_addr[15]` is 1. Writes below 0x8000, or writes with `cpu_ce` low, leave every output mapping unchanged.
- R2: An active-low `rst_n` clears the latch to zero. After reset, 0x8000 maps to program offset 0 and, in variant 1, character bank 0 is selected.
- R3: The value loaded is `cpu_wdata & rom_data`, sampled at the loading edge.
- R4: In variant 0, a CPU address with bit 14 clear maps to `{latch, cpu_addr[13:0]}`, truncated to the program address width.
- R5: In variant 0, a CPU address with bit 14 set always maps to the last 16 kB bank, whatever the latch holds.
- R6: In variant 1, the program address is `{latch[5:4], cpu_addr[14:0]}`, truncated to the program address width.
- R7: In variant 1, the character address is `{latch[1:0], ppu_addr[12:0]}`, truncated to the character address width. In variant 0, the character address is `ppu_addr[12:0]`.
- R8: Bank numbers wrap modulo the configured ROM size. Bank bits above the ROM's address width are dropped.
- R9: `nt_page` equals `ppu_addr[10]` when `mirror_vert` is 1, and `ppu_addr[11]` when it is 0.
- R10: Between loading writes, the latch holds its value over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Data the CPU drives on a write |
| rom_data | input | 8 | Byte the program ROM drives at `cpu_addr` |
| cpu_we | input | 1 | CPU write strobe |
| cpu_ce | input | 1 | Cartridge chip enable |
| ppu_addr | input | 14 | Picture-side address |
| mirror_vert | input | 1 | Mirroring strap: 1 for vertical, 0 for horizontal |
| prg_addr | output | PRG_AW | Banked program ROM address |
| chr_addr | output | CHR_AW | Banked character ROM address |
| nt_page | output | 1 | Nametable page select |

## Verification
All three outputs are combinational in the current addresses and the latch. An address change therefore shows up in the same cycle. A loading write shows up only after the rising edge that captures it.

The bench drives inputs just after a falling edge and lets one rising edge pass. It then compares every output at the next falling edge against a behavioural model, which updates on that same rising edge. Every write is therefore checked exactly one edge after it is applied, and every pure address change is checked in the cycle it is applied.

Both variants run side by side on the same stimulus. Their sizes are chosen so that the bank fields wrap.

// File: rtl/discrete_bank_latch.sv
module discrete_bank_latch #(
  parameter int VARIANT = 0,
  parameter int PRG_KB  = 128,
  parameter int CHR_KB  = 8,
  localparam int PRG_AW = $clog2(PRG_KB) + 10,
  localparam int CHR_AW = $clog2(CHR_KB) + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [7:0]        rom_data,
  input  logic              cpu_we,
  input  logic              cpu_ce,
  input  logic [13:0]       ppu_addr,
  input  logic              mirror_vert,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              nt_page
);

  logic [7:0]  bank_q;
  logic [31:0] prg_full;
  logic [31:0] chr_full;
  logic        load;

  assign load = cpu_we & cpu_ce & cpu_addr[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= cpu_wdata & rom_data;
  end

  generate
    if (VARIANT == 0) begin : g_fixed_top
      assign prg_full = cpu_addr[14] ? {18'h3FFFF, cpu_addr[13:0]}
                                     : {10'd0, bank_q, cpu_addr[13:0]};
      assign chr_full = {19'd0, ppu_addr[12:0]};
    end else begin : g_packed
      assign prg_full = {15'd0, bank_q[5:4], cpu_addr[14:0]};
      assign chr_full = {17'd0, bank_q[1:0], ppu_addr[12:0]};
    end
  endgenerate

  assign prg_addr = prg_full[PRG_AW-1:0];
  assign chr_addr = chr_full[CHR_AW-1:0];
  assign nt_page  = mirror_vert ? ppu_addr[10] : ppu_addr[11];

endmodule

// File: rtl/discrete_bank_latch_chk.sv
module discrete_bank_latch_chk #(
  parameter int VARIANT = 0,
  parameter int PRG_AW  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        rom_data,
  input logic              cpu_we,
  input logic              cpu_ce,
  input logic [PRG_AW-1:0] prg_addr,
  input logic [7:0]        bank_q
);

  a_r3_and_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_ce && cpu_addr[15]) |=> bank_q == $past(cpu_wdata & rom_data));

  a_r1_low_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_addr[15]) |=> $stable(bank_q));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_ce) |=> $stable(bank_q));

  a_r5_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == 0 && cpu_addr[14]) |-> (&prg_addr[PRG_AW-1:14]));

  a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    prg_addr[13:0] == cpu_addr[13:0]);

endmodule

bind discrete_bank_latch discrete_bank_latch_chk #(
  .VARIANT(VARIANT), .PRG_AW(PRG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .rom_data(rom_data), .cpu_we(cpu_we), .cpu_ce(cpu_ce),
  .prg_addr(prg_addr), .bank_q(bank_q)
);

// File: tb/sim_discrete_bank_latch.sv
module sim_discrete_bank_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rom_data = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_ce = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        mirror_vert = 1'b1;

  logic [16:0] prg0;
  logic [12:0] chr0;
  logic        nt0;
  logic [15:0] prg1;
  logic [13:0] chr1;
  logic        nt1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int model = 0;

  always #10 clk = ~clk;

  discrete_bank_latch #(.VARIANT(0), .PRG_KB(128), .CHR_KB(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rom_data(rom_data), .cpu_we(cpu_we), .cpu_ce(cpu_ce), .ppu_addr(ppu_addr),
    .mirror_vert(mirror_vert), .prg_addr(prg0), .chr_addr(chr0), .nt_page(nt0));

  discrete_bank_latch #(.VARIANT(1), .PRG_KB(64), .CHR_KB(16)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rom_data(rom_data), .cpu_we(cpu_we), .cpu_ce(cpu_ce), .ppu_addr(ppu_addr),
    .mirror_vert(mirror_vert), .prg_addr(prg1), .chr_addr(chr1), .nt_page(nt1));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model = 0;
    else if (cpu_we && cpu_ce && cpu_addr[15]) model = int'(cpu_wdata & rom_data);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 5000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int off = int'(cpu_addr) & 16'h3FFF;
    int e0 = cpu_addr[14] ? (7 * 16384 + off) : ((model % 8) * 16384 + off);
    int e1 = (((model >> 4) & 3) % 2) * 32768 + (int'(cpu_addr) & 16'h7FFF);
    int c1 = ((model & 3) % 2) * 8192 + (int'(ppu_addr) & 16'h1FFF);
    int ent = mirror_vert ? int'(ppu_addr[10]) : int'(ppu_addr[11]);
    chk({tag, " v0 prg"}, int'(prg0), e0);
    chk({tag, " v1 prg"}, int'(prg1), e1);
    chk({tag, " v0 chr (R7)"}, int'(chr0), int'(ppu_addr) & 16'h1FFF);
    chk({tag, " v1 chr"}, int'(chr1), c1);
    chk({tag, " nt (R9)"}, int'(nt0), ent);
    chk({tag, " nt (R9)"}, int'(nt1), ent);
  endtask

  task automatic step(string tag, logic [15:0] a, logic [7:0] d, logic [7:0] r,
                      logic we, logic ce, logic [13:0] pa);
    cpu_addr = a; cpu_wdata = d; rom_data = r; cpu_we = we; cpu_ce = ce; ppu_addr = pa;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    cpu_addr = 16'h8123; ppu_addr = 14'h0456;
    #1;
    chk("R2 reset v0 prg", int'(prg0), 32'h0123);
    chk("R2 reset v1 prg", int'(prg1), 32'h0123);
    chk("R2 reset v1 chr", int'(chr1), 32'h0456);
    @(negedge clk);
    rst_n = 1'b1;
    step("R2 idle", 16'h8123, 8'h00, 8'h00, 1'b0, 1'b0, 14'h0456);
    step("R1 R3 R4 load", 16'h8000, 8'h05, 8'hFF, 1'b1, 1'b1, 14'h0100);
    step("R4 read low", 16'h9ABC, 8'h00, 8'h00, 1'b0, 1'b1, 14'h1FFF);
    step("R3 conflict", 16'hA000, 8'hFF, 8'h32, 1'b1, 1'b1, 14'h0000);
    step("R6 R7 read", 16'hF00F, 8'h00, 8'h00, 1'b0, 1'b1, 14'h1234);
    step("R1 low write", 16'h6000, 8'h07, 8'hFF, 1'b1, 1'b1, 14'h0000);
    step("R1 no ce", 16'h8000, 8'h07, 8'hFF, 1'b1, 1'b0, 14'h0000);
    step("R1 after ignored", 16'h8001, 8'h00, 8'h00, 1'b0, 1'b0, 14'h0000);
    step("R5 fixed top", 16'hC000, 8'h00, 8'h00, 1'b0, 1'b1, 14'h0000);
    step("R5 fixed top end", 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b1, 14'h0000);
    step("R8 wrap load", 16'hC123, 8'h3B, 8'hFF, 1'b1, 1'b1, 14'h0000);
    step("R8 wrap read", 16'h8010, 8'h00, 8'h00, 1'b0, 1'b1, 14'h1000);
    step("R9 vert", 16'h8000, 8'h00, 8'h00, 1'b0, 1'b0, 14'h2400);
    mirror_vert = 1'b0;
    step("R9 horiz", 16'h8000, 8'h00, 8'h00, 1'b0, 1'b0, 14'h2400);
    step("R9 horiz b11", 16'h8000, 8'h00, 8'h00, 1'b0, 1'b0, 14'h2800);
    for (int i = 0; i < 6; i++)
      step("R10 hold", 16'h8000 + 16'(i * 16'h0777), 8'h00, 8'h00, 1'b0, 1'b1, 14'(i * 300));
    for (int i = 0; i < 24; i++)
      step("R3 R6 R8 sweep", 16'h8000 + 16'(i * 16'h0A51), 8'(i * 37 + 5),
           8'(8'hFF ^ 8'(i * 11)), 1'b1, 1'b1, 14'(i * 613));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule